// File: doc/BRIEF.md
# Shared Time Base and Watchdog Timer

This block produces a slow periodic signal and a watchdog timeout from one shared ripple-style divider chain. A source tick arrives as a one-cycle pulse on `src_tick_i`. It comes either from a 32 kHz-class crystal, which is used directly, or from a 256 kHz-class source, which a three-stage prescaler first divides by eight. A base divider of `BASE_DIV_BITS` stages is followed by seven rate stages. A 3-bit rate code selects one of eight taps: code 7 is the fastest rate (128 Hz with the default eight base stages) and code 0 is the slowest (1 Hz). A two-stage counter after the selected tap counts whole periods. On the fourth period it sets a sticky timeout flag.

Control arrives as one-cycle command strobes from an upstream command decoder. These pins carry no stream, so there is no valid/ready handshake. A strobe is sampled on the rising clock edge and takes effect from the next cycle. The single interrupt output is modelled as open-drain: `irq_oe_o` says whether the pin is driven, and `irq_level_o` gives the level. In timer routing the level is the selected tap. In watchdog routing the level is low while the timeout flag is set and high otherwise. A test parameter shortens the base divider so that the slow rates can be reached in short runs.

Top module: `tbase_wdog`

## Requirements
- R1: After reset the counters are halted and cleared, the routing is timer, the output is disabled (`irq_oe_o` = 0), the rate code is 0, the system is off, the timeout flag is clear and `irq_level_o` is 0.
- R2: While counting with rate code r, the timer-routed level is a square wave. Its period is 2^(BASE_DIV_BITS+7-r) base ticks, and its level is 0 during the first half of each period counted from a clear.
- R3: With `src_sel_i` = 2'b00 (crystal) every source tick is a base tick. With 2'b01 (internal RC), 2'b10 (external) or 2'b11 (treated as RC), only every eighth source tick is a base tick.
- R4: The timeout flag is set on the fourth completed period of the selected rate after a watchdog clear. It then stays set until a watchdog clear or an output disable. While the routing is watchdog, the level is 0 when the flag is set and 1 when it is clear.
- R5: The watchdog-disable and timer-disable strobes both halt the shared chain. The watchdog-enable and timer-enable strobes both start it. Watchdog-enable selects watchdog routing, and timer-enable selects timer routing.
- R6: The watchdog-clear strobe zeroes the divider chain, the prescaler, the two-stage period counter and the flag. The timer-clear strobe zeroes only the divider chain and the prescaler.
- R7: The output-enable strobe sets `irq_oe_o` to 1. The output-disable strobe sets it to 0 and also releases the timeout flag.
- R8: While the system is off, counting halts for source codes 2'b00, 2'b01 and 2'b11. With source code 2'b10 (external), the system-off state is ignored and counting continues.
- R9: A clear strobe in the same cycle as a source tick wins: no count, no prescale step and no timeout happen in that cycle.
- R10: When the disable and enable strobes of one pair (run, output, system) arrive in the same cycle, disable wins. When timer-enable and watchdog-enable arrive together, timer routing wins.
- R11: A rate write (`cmd_rate_we_i` with `rate_i`) changes the selected tap from the next cycle on, without clearing any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | 1 | One-cycle pulse per source clock period |
| src_sel_i | input | 2 | Source code: 00 crystal, 01 RC, 10 external, 11 as RC |
| cmd_sys_en_i | input | 1 | System-on strobe |
| cmd_sys_dis_i | input | 1 | System-off strobe |
| cmd_tmr_en_i | input | 1 | Start chain, route time base |
| cmd_tmr_dis_i | input | 1 | Halt chain |
| cmd_wdt_en_i | input | 1 | Start chain, route timeout flag |
| cmd_wdt_dis_i | input | 1 | Halt chain |
| cmd_clr_tmr_i | input | 1 | Clear divider chain and prescaler |
| cmd_clr_wdt_i | input | 1 | Clear chain, prescaler, period counter and flag |
| cmd_out_en_i | input | 1 | Enable the interrupt output |
| cmd_out_dis_i | input | 1 | Disable the output and release the flag |
| cmd_rate_we_i | input | 1 | Load `rate_i` as the rate code |
| rate_i | input | 3 | Rate code, 7 fastest, 0 slowest |
| irq_level_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin drive enable |

## Verification
Two events can land in the same cycle. The first is a clear strobe together with the source tick that would complete the fourth watchdog period, or that would advance the chain. The bench creates this by keeping the tick high on every cycle and repeating the watchdog clear at a spacing just under the timeout, so that clears fall on ticking cycles. The second is a timeout event in the same cycle as an output disable. Both are judged by comparing against a behavioural model on every cycle. The model gives the clear priority over the tick, and the release priority over the flag set.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  typedef enum logic [1:0] {
    SRC_XTAL = 2'b00,
    SRC_RC   = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_RC2  = 2'b11
  } src_e;

  typedef enum logic {
    ROUTE_TMR = 1'b0,
    ROUTE_WDT = 1'b1
  } route_e;
endpackage

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
  import tbw_pkg::*;
#(
  parameter int RB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_en,
  input  logic          sys_dis,
  input  logic          tmr_en,
  input  logic          tmr_dis,
  input  logic          wdt_en,
  input  logic          wdt_dis,
  input  logic          out_en,
  input  logic          out_dis,
  input  logic          rate_we,
  input  logic [RB-1:0] rate_in,
  output logic          run_o,
  output route_e        route_o,
  output logic          oe_o,
  output logic          sys_on_o,
  output logic [RB-1:0] rate_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o    <= 1'b0;
      route_o  <= ROUTE_TMR;
      oe_o     <= 1'b0;
      sys_on_o <= 1'b0;
      rate_o   <= '0;
    end else begin
      // disable beats enable within each pair
      if (wdt_dis || tmr_dis)     run_o <= 1'b0;
      else if (wdt_en || tmr_en)  run_o <= 1'b1;

      if (tmr_en)                 route_o <= ROUTE_TMR;
      else if (wdt_en)            route_o <= ROUTE_WDT;

      if (out_dis)                oe_o <= 1'b0;
      else if (out_en)            oe_o <= 1'b1;

      if (sys_dis)                sys_on_o <= 1'b0;
      else if (sys_en)            sys_on_o <= 1'b1;

      if (rate_we)                rate_o <= rate_in;
    end
  end
endmodule

// File: rtl/tbw_prescaler.sv
module tbw_prescaler #(
  parameter int PB = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic bypass,
  output logic base_tick_o
);
  logic [PB-1:0] pre_q;

  assign base_tick_o = adv && (bypass || (&pre_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (clr)              pre_q <= '0;
    else if (adv && !bypass)   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tbw_chain.sv
module tbw_chain #(
  parameter int CW    = 15,
  parameter int RB    = 3,
  localparam int NRATE = 1 << RB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [RB-1:0] rate,
  output logic          tap_o,
  output logic          evt_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0]    cnt_q;
  logic [NRATE-1:0] taps;
  logic [NRATE-1:0] wraps;

  // tap k sits k stages below the top of the chain
  for (genvar k = 0; k < NRATE; k++) begin : g_tap
    assign taps[k]  = cnt_q[CW-1-k];
    assign wraps[k] = &cnt_q[CW-1-k:0];
  end

  assign tap_o = taps[rate];
  assign evt_o = step && wraps[rate];
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog #(
  parameter int WB = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic evt,
  input  logic release_flag,
  output logic flag_o
);
  logic [WB-1:0] per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      flag_o <= 1'b0;
    end else if (clr) begin
      per_q  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (release_flag)           flag_o <= 1'b0;
      else if (evt && (&per_q))   flag_o <= 1'b1;
      if (evt)                    per_q  <= per_q + 1'b1;
    end
  end
endmodule

// File: rtl/tbase_wdog.sv
module tbase_wdog
  import tbw_pkg::*;
#(
  parameter int BASE_DIV_BITS = 8,
  parameter int RB            = 3,
  parameter int PB            = 3,
  parameter int WB            = 2,
  localparam int CW           = BASE_DIV_BITS + (1 << RB) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_tick_i,
  input  logic [1:0]    src_sel_i,
  input  logic          cmd_sys_en_i,
  input  logic          cmd_sys_dis_i,
  input  logic          cmd_tmr_en_i,
  input  logic          cmd_tmr_dis_i,
  input  logic          cmd_wdt_en_i,
  input  logic          cmd_wdt_dis_i,
  input  logic          cmd_clr_tmr_i,
  input  logic          cmd_clr_wdt_i,
  input  logic          cmd_out_en_i,
  input  logic          cmd_out_dis_i,
  input  logic          cmd_rate_we_i,
  input  logic [RB-1:0] rate_i,
  output logic          irq_level_o,
  output logic          irq_oe_o
);
  logic          run_q;
  route_e        route_q;
  logic          sys_on_q;
  logic [RB-1:0] rate_q;
  logic          active;
  logic          clr_any;
  logic          base_tick;
  logic          tap;
  logic          evt;
  logic          wd_flag;
  logic [CW-1:0] chain_cnt;

  tbw_ctrl #(.RB(RB)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sys_en(cmd_sys_en_i), .sys_dis(cmd_sys_dis_i),
    .tmr_en(cmd_tmr_en_i), .tmr_dis(cmd_tmr_dis_i),
    .wdt_en(cmd_wdt_en_i), .wdt_dis(cmd_wdt_dis_i),
    .out_en(cmd_out_en_i), .out_dis(cmd_out_dis_i),
    .rate_we(cmd_rate_we_i), .rate_in(rate_i),
    .run_o(run_q), .route_o(route_q), .oe_o(irq_oe_o),
    .sys_on_o(sys_on_q), .rate_o(rate_q)
  );

  assign clr_any = cmd_clr_tmr_i || cmd_clr_wdt_i;
  assign active  = run_q && (sys_on_q || (src_sel_i == SRC_EXT));

  tbw_prescaler #(.PB(PB)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .clr(clr_any),
    .adv(active && src_tick_i && !clr_any),
    .bypass(src_sel_i == SRC_XTAL),
    .base_tick_o(base_tick)
  );

  tbw_chain #(.CW(CW), .RB(RB)) u_chain (
    .clk(clk), .rst_n(rst_n),
    .clr(clr_any), .step(base_tick), .rate(rate_q),
    .tap_o(tap), .evt_o(evt), .cnt_o(chain_cnt)
  );

  tbw_watchdog #(.WB(WB)) u_wd (
    .clk(clk), .rst_n(rst_n),
    .clr(cmd_clr_wdt_i), .evt(evt), .release_flag(cmd_out_dis_i),
    .flag_o(wd_flag)
  );

  assign irq_level_o = (route_q == ROUTE_WDT) ? !wd_flag : tap;
endmodule

// File: rtl/tbase_wdog_chk.sv
module tbase_wdog_chk #(
  parameter int CW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_clr_wdt_i,
  input logic          cmd_clr_tmr_i,
  input logic          cmd_out_dis_i,
  input logic          cmd_wdt_dis_i,
  input logic          cmd_tmr_dis_i,
  input logic [1:0]    src_sel_i,
  input logic          irq_oe_o,
  input logic          wd_flag,
  input logic          run_q,
  input logic          sys_on_q,
  input logic [CW-1:0] chain_cnt
);
  assert_clr_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr_wdt_i |=> !wd_flag);

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !cmd_clr_wdt_i && !cmd_out_dis_i) |=> wd_flag);

  assert_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cmd_clr_wdt_i && !cmd_clr_tmr_i) |=> $stable(chain_cnt));

  assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_out_dis_i |=> !irq_oe_o);

  assert_dis_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wdt_dis_i || cmd_tmr_dis_i) |=> !run_q);

  assert_sys_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_on_q && src_sel_i != 2'b10 && !cmd_clr_wdt_i && !cmd_clr_tmr_i)
      |=> $stable(chain_cnt));
endmodule

bind tbase_wdog tbase_wdog_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd_clr_wdt_i(cmd_clr_wdt_i), .cmd_clr_tmr_i(cmd_clr_tmr_i),
  .cmd_out_dis_i(cmd_out_dis_i), .cmd_wdt_dis_i(cmd_wdt_dis_i),
  .cmd_tmr_dis_i(cmd_tmr_dis_i), .src_sel_i(src_sel_i),
  .irq_oe_o(irq_oe_o), .wd_flag(wd_flag), .run_q(run_q),
  .sys_on_q(sys_on_q), .chain_cnt(chain_cnt)
);

// File: tb/tbase_wdog_tb.sv
module tbase_wdog_tb;
  localparam int BASE = 2;
  localparam int CW   = BASE + 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_tick = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic sys_en = 0, sys_dis = 0, tmr_en = 0, tmr_dis = 0, wdt_en = 0, wdt_dis = 0;
  logic clr_tmr = 0, clr_wdt = 0, out_en = 0, out_dis = 0, rate_we = 0;
  logic [2:0] rate = 3'd0;
  logic irq_level, irq_oe;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  int tick_mode = 0;   // 0 every cycle, 1 two of three, 2 none
  int cyc = 0;

  // behavioural model
  int m_cnt = 0, m_pre = 0, m_wc = 0, m_rate = 0;
  bit m_flag = 0, m_run = 0, m_wdt_route = 0, m_oe = 0, m_sys = 0;

  always #5 clk = ~clk;

  tbase_wdog #(.BASE_DIV_BITS(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick), .src_sel_i(src_sel),
    .cmd_sys_en_i(sys_en), .cmd_sys_dis_i(sys_dis),
    .cmd_tmr_en_i(tmr_en), .cmd_tmr_dis_i(tmr_dis),
    .cmd_wdt_en_i(wdt_en), .cmd_wdt_dis_i(wdt_dis),
    .cmd_clr_tmr_i(clr_tmr), .cmd_clr_wdt_i(clr_wdt),
    .cmd_out_en_i(out_en), .cmd_out_dis_i(out_dis),
    .cmd_rate_we_i(rate_we), .rate_i(rate),
    .irq_level_o(irq_level), .irq_oe_o(irq_oe)
  );

  function automatic bit m_level();
    if (m_wdt_route) return !m_flag;
    return bit'((m_cnt >> (CW - 1 - m_rate)) & 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_wc = 0; m_rate = 0;
      m_flag = 0; m_run = 0; m_wdt_route = 0; m_oe = 0; m_sys = 0;
    end else begin
      automatic bit act = m_run && (m_sys || src_sel == 2'b10);
      automatic bit base = 0;
      automatic bit ev = 0;
      automatic int per = 1 << (CW - m_rate);
      if (clr_tmr || clr_wdt) begin
        m_cnt = 0; m_pre = 0;
      end else if (act && src_tick) begin
        if (src_sel == 2'b00) base = 1;
        else begin
          if (m_pre == 7) base = 1;
          m_pre = (m_pre + 1) % 8;
        end
        if (base) begin
          ev = (m_cnt % per) == per - 1;
          m_cnt = (m_cnt + 1) % (1 << CW);
        end
      end
      if (clr_wdt) begin
        m_wc = 0; m_flag = 0;
      end else begin
        if (out_dis) m_flag = 0;
        else if (ev && m_wc == 3) m_flag = 1;
        if (ev) m_wc = (m_wc + 1) % 4;
      end
      if (wdt_dis || tmr_dis) m_run = 0; else if (wdt_en || tmr_en) m_run = 1;
      if (tmr_en) m_wdt_route = 0; else if (wdt_en) m_wdt_route = 1;
      if (out_dis) m_oe = 0; else if (out_en) m_oe = 1;
      if (sys_dis) m_sys = 0; else if (sys_en) m_sys = 1;
      if (rate_we) m_rate = rate;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison and tick pattern, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(irq_oe == m_oe, cur_req, irq_oe, m_oe);
      check(irq_level == m_level(), cur_req, irq_level, m_level());
    end
    case (tick_mode)
      0: src_tick = 1'b1;
      1: src_tick = (cyc % 3) != 0;
      default: src_tick = 1'b0;
    endcase
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic set_rate(input int r);
    @(negedge clk); rate = 3'(r); rate_we = 1'b1;
    @(negedge clk); rate_we = 1'b0;
  endtask

  initial begin
    idle(3);
    cur_req = "R1";
    check(irq_oe == 1'b0, "R1", irq_oe, 0);
    check(irq_level == 1'b0, "R1", irq_level, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    check(irq_level == 1'b0, "R1", irq_level, 0);

    // R2: time base rates, crystal source, varied tick patterns
    cur_req = "R2";
    strobe(sys_en); strobe(out_en); set_rate(7);
    strobe(clr_tmr); strobe(tmr_en);
    idle(200);
    tick_mode = 1; set_rate(5); idle(300);
    tick_mode = 0; set_rate(0); idle(1100);

    // R11: rate change mid-count
    cur_req = "R11";
    set_rate(6); idle(60); set_rate(3); idle(150);

    // R3: prescaled sources
    cur_req = "R3";
    src_sel = 2'b01; set_rate(7); strobe(clr_tmr); idle(300);
    src_sel = 2'b11; idle(100);
    tick_mode = 1; src_sel = 2'b10; idle(200);
    tick_mode = 0; src_sel = 2'b00;

    // R4: watchdog timeout and stickiness
    cur_req = "R4";
    set_rate(7); strobe(clr_wdt); strobe(wdt_en);
    idle(40);
    check(irq_level == 1'b0, "R4", irq_level, 0);
    idle(100);
    check(irq_level == 1'b0, "R4", irq_level, 0);

    // R6: watchdog clear releases; timer clear leaves the flag
    cur_req = "R6";
    strobe(clr_wdt); idle(2);
    check(irq_level == 1'b1, "R6", irq_level, 1);
    idle(40); strobe(clr_tmr); idle(2);
    check(irq_level == 1'b0, "R6", irq_level, 0);

    // R7: output disable releases flag and drops oe
    cur_req = "R7";
    strobe(out_dis); idle(1);
    check(irq_oe == 1'b0, "R7", irq_oe, 0);
    strobe(out_en); idle(30);

    // R9: clear on ticking cycles just before timeout; collision with out_dis
    cur_req = "R9";
    strobe(clr_wdt);
    for (int i = 0; i < 12; i++) begin idle(13); strobe(clr_wdt); end
    check(irq_level == 1'b1, "R9", irq_level, 1);
    for (int i = 0; i < 20; i++) begin idle(i); strobe(out_dis); strobe(out_en); end

    // R5: disable halts, enable restarts, routing
    cur_req = "R5";
    strobe(clr_wdt); strobe(wdt_dis); idle(80);
    check(irq_level == 1'b1, "R5", irq_level, 1);
    strobe(tmr_en); idle(50); strobe(tmr_dis); idle(50);
    strobe(wdt_en); idle(60);

    // R8: system off halts except external source
    cur_req = "R8";
    strobe(tmr_en); strobe(sys_dis); idle(80);
    src_sel = 2'b01; idle(80);
    src_sel = 2'b10; idle(80);
    src_sel = 2'b00;

    // R10: same-cycle disable and enable
    cur_req = "R10";
    @(negedge clk); sys_en = 1; sys_dis = 1; wdt_en = 1; tmr_en = 1; tmr_dis = 1;
    out_en = 1; out_dis = 1;
    @(negedge clk); sys_en = 0; sys_dis = 0; wdt_en = 0; tmr_en = 0; tmr_dis = 0;
    out_en = 0; out_dis = 0;
    check(irq_oe == 1'b0, "R10", irq_oe, 0);
    idle(40);
    strobe(sys_en); strobe(out_en); strobe(tmr_en); idle(60);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired in phase %s", cur_req);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule